// File: doc/BRIEF.md
# SMBus Indexed Block-Transfer Register Slave

This block is a slave on a two-wire SMBus segment that holds a small bank of 8-bit configuration registers. A host reaches the bank only through block transfers. Each write names a starting index and a byte count, then supplies the data. Each read first sets the index in a short write phase, then issues a repeated START with the read address. The slave answers with a byte count followed by the registers, starting at that index.

Both bus lines are sampled in the system clock domain through a short synchronizer. START and STOP are recognised from SDA edges while SCL is high. The slave pulls SDA low through an open-drain enable and never lets it float high by itself. The index pointer steps after every data byte in both directions and wraps at the end of the bank. The last register of the bank is the count register, and its value is returned as the count byte of every read. The bank has 8 registers by default, and the 7-bit device address defaults to 0x69, which gives the address bytes 0xD2 and 0xD3.

Top module: `smb_blk_slave`

## Requirements
- R1: After reset the slave does not drive SDA. The count register (index 7) holds 8 and every other register holds 0.
- R2: The address bytes 0xD2 (write) and 0xD3 (read) are acknowledged: SDA is pulled low during the ninth SCL pulse of the byte.
- R3: Any other address byte is not acknowledged. After it, the slave drives nothing and writes no register until the next START.
- R4: In a block write the index byte N, the count byte X and the first X data bytes are all acknowledged, and data byte k (counted from 0) is stored in register (N+k) mod 8.
- R5: Data bytes sent after the X-th one in a block write are not acknowledged and are discarded.
- R6: Only the low three bits of the index byte are used (index taken mod 8), and the register pointer wraps from 7 to 0.
- R7: A block read follows the sequence 0xD2, N, repeated START, 0xD3. The slave then sends the count register first and registers N, N+1, … (mod 8) after it, MSB first, for as long as the host acknowledges.
- R8: An ordinary block write that reaches index 7 updates the count register, and the next read returns the new value as its count byte.
- R9: After the host does not acknowledge a byte the slave sent, the slave keeps SDA released until the next START, even if SCL keeps toggling.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both bus lines are oversampled by it |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SMBus clock line as seen on the wire |
| sda_i | input | 1 | SMBus data line as seen on the wire |
| sda_oe | output | 1 | Pull-down enable for SDA; 1 pulls the line low, 0 releases it |

## Verification
Two things can happen at the same clock edge: the data-byte write that lands on the count register, and the pointer wrap from the last index back to the first. The bench provokes this with a block write that starts at index 6 and carries three bytes, so the second byte lands on the count register and the third on register 0. The result is judged by a following read. Its count byte must equal the value just written, and its data must follow the wrapped order. Random block writes whose start index and length cross the wrap, with surplus bytes mixed in, repeat the same collision with other values.

// File: rtl/smb_pkg.sv
package smb_pkg;

  typedef enum logic [2:0] {
    M_IDLE,
    M_RX,
    M_ACK,
    M_TX,
    M_HACK,
    M_SKIP
  } link_mode_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_IDX,
    K_CNT,
    K_WDAT
  } byte_kind_t;

  // next register index, wrapping at the bank depth
  function automatic int unsigned wrap_inc(int unsigned idx, int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

  // full address byte from a 7-bit device address and the direction bit
  function automatic logic [7:0] addr_byte(logic [6:0] dev, logic rd);
    return {dev, rd};
  endfunction

  // reset contents: the count register starts at the bank depth, the rest at zero
  function automatic logic [7:0] reg_reset(int unsigned idx, int unsigned cnt_idx, int unsigned depth);
    return (idx == cnt_idx) ? 8'(depth) : 8'h00;
  endfunction

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_p;
  logic              sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_p    <= scl_s;
      sda_p    <= sda_s;
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/smb_regbank.sv
module smb_regbank
  import smb_pkg::*;
#(
  parameter int NREG    = 8,
  parameter int AW      = 3,
  parameter int CNT_IDX = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic [7:0]    cnt_data
);

  logic [7:0]      regs [NREG];
  logic [NREG-1:0] hit;

  for (genvar g = 0; g < NREG; g++) begin : g_dec
    assign hit[g] = wr_en && (wr_idx == AW'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= reg_reset(i, CNT_IDX, NREG);
    end else begin
      for (int i = 0; i < NREG; i++) if (hit[i]) regs[i] <= wr_data;
    end
  end

  assign rd_data  = regs[rd_idx];
  assign cnt_data = regs[CNT_IDX];

  AST_ONE_LANE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R4
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs[$past(wr_idx)] == $past(wr_data)); // R4

endmodule

// File: rtl/smb_link.sv
module smb_link
  import smb_pkg::*;
#(
  parameter int         NREG     = 8,
  parameter int         AW       = 3,
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic [7:0]    rd_data,
  input  logic [7:0]    cnt_data,
  output logic [AW-1:0] ptr,
  output logic          wr_en,
  output logic [7:0]    wr_data,
  output logic          sda_oe
);

  localparam logic [7:0] WR_ADDR = addr_byte(DEV_ADDR, 1'b0);
  localparam logic [7:0] RD_ADDR = addr_byte(DEV_ADDR, 1'b1);

  link_mode_t    mode;
  byte_kind_t    kind;
  logic [3:0]    bitcnt;
  logic [7:0]    shr;
  logic [7:0]    txsh;
  logic [7:0]    remain;
  logic          ack_q;
  logic          go_tx;
  logic          host_ack;
  logic          oe_q;
  logic [AW-1:0] ptr_q;

  // named internal events
  logic [7:0]    rx_byte;
  logic          byte_end;
  logic          ack_n;
  logic [AW-1:0] ptr_next;

  always_comb begin
    rx_byte  = {shr[6:0], sda_s};
    byte_end = (mode == M_RX) && scl_rise && (bitcnt == 4'd7);
    ptr_next = AW'(wrap_inc(32'(ptr_q), NREG));
    unique case (kind)
      K_ADDR:  ack_n = (rx_byte == WR_ADDR) || (rx_byte == RD_ADDR);
      K_WDAT:  ack_n = (remain != 8'd0);
      default: ack_n = 1'b1;
    endcase
  end

  assign wr_en   = byte_end && (kind == K_WDAT) && (remain != 8'd0);
  assign wr_data = rx_byte;
  assign ptr     = ptr_q;
  assign sda_oe  = oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= M_IDLE;
      kind     <= K_ADDR;
      bitcnt   <= '0;
      shr      <= '0;
      txsh     <= '0;
      remain   <= '0;
      ack_q    <= 1'b0;
      go_tx    <= 1'b0;
      host_ack <= 1'b0;
      oe_q     <= 1'b0;
      ptr_q    <= '0;
    end else if (stop_ev) begin
      mode  <= M_IDLE;
      oe_q  <= 1'b0;
      go_tx <= 1'b0;
    end else if (start_ev) begin
      mode   <= M_RX;
      kind   <= K_ADDR;
      bitcnt <= '0;
      oe_q   <= 1'b0;
      go_tx  <= 1'b0;
    end else begin
      unique case (mode)
        M_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shr    <= rx_byte;
            bitcnt <= bitcnt + 4'd1;
            if (byte_end) begin
              ack_q <= ack_n;
              unique case (kind)
                K_ADDR: begin
                  go_tx <= (rx_byte == RD_ADDR);
                  kind  <= K_IDX;
                end
                K_IDX: begin
                  ptr_q <= rx_byte[AW-1:0];
                  kind  <= K_CNT;
                end
                K_CNT: begin
                  remain <= rx_byte;
                  kind   <= K_WDAT;
                end
                default: begin
                  if (remain != 8'd0) begin
                    ptr_q  <= ptr_next;
                    remain <= remain - 8'd1;
                  end
                end
              endcase
            end
          end else if (scl_fall && bitcnt == 4'd8) begin
            mode <= M_ACK;
            oe_q <= ack_q;
          end
        end
        M_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (!ack_q) begin
              mode <= M_SKIP;
              oe_q <= 1'b0;
            end else if (go_tx) begin
              mode  <= M_TX;
              go_tx <= 1'b0;
              txsh  <= cnt_data;
              oe_q  <= ~cnt_data[7];
            end else begin
              mode <= M_RX;
              oe_q <= 1'b0;
            end
          end
        end
        M_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              mode <= M_HACK;
              oe_q <= 1'b0;
            end else begin
              txsh   <= {txsh[6:0], 1'b0};
              oe_q   <= ~txsh[6];
              bitcnt <= bitcnt + 4'd1;
            end
          end
        end
        M_HACK: begin
          if (scl_rise) host_ack <= ~sda_s;
          if (scl_fall) begin
            if (host_ack) begin
              mode   <= M_TX;
              bitcnt <= '0;
              txsh   <= rd_data;
              oe_q   <= ~rd_data[7];
              ptr_q  <= ptr_next;
            end else begin
              mode <= M_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> !$past(scl_s)); // R10
  AST_QUIET_AFTER_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SKIP || mode == M_IDLE) |-> !oe_q); // R9
  AST_DRIVE_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (mode == M_ACK || mode == M_TX)); // R2
  AST_WR_CONSUMES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ($past(remain) - remain) == 8'd1); // R5
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ptr_q != $past(ptr_q)); // R6
  AST_START_REARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && !stop_ev) |=> (mode == M_RX && bitcnt == 4'd0 && !oe_q)); // R3

endmodule

// File: rtl/smb_blk_slave.sv
module smb_blk_slave #(
  parameter int         NREG        = 8,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);

  localparam int AW      = $clog2(NREG);
  localparam int CNT_IDX = NREG - 1;

  logic          scl_s;
  logic          sda_s;
  logic          scl_rise;
  logic          scl_fall;
  logic          start_ev;
  logic          stop_ev;
  logic [7:0]    rd_data;
  logic [7:0]    cnt_data;
  logic [AW-1:0] ptr;
  logic          wr_en;
  logic [7:0]    wr_data;

  smb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  smb_link #(.NREG(NREG), .AW(AW), .DEV_ADDR(DEV_ADDR)) u_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .rd_data  (rd_data),
    .cnt_data (cnt_data),
    .ptr      (ptr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .sda_oe   (sda_oe)
  );

  smb_regbank #(.NREG(NREG), .AW(AW), .CNT_IDX(CNT_IDX)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (ptr),
    .wr_data  (wr_data),
    .rd_idx   (ptr),
    .rd_data  (rd_data),
    .cnt_data (cnt_data)
  );

endmodule

// File: tb/smb_blk_slave_test.sv
module smb_blk_slave_test;

  localparam int NREG = 8;
  localparam int Q    = 8;

  logic clk   = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1;
  logic sda_h = 1'b1;
  wire  sda_oe_w;
  wire  sda_line = sda_h & ~sda_oe_w;

  always #4 clk = ~clk;

  smb_blk_slave #(.NREG(NREG)) uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_h),
    .sda_i  (sda_line),
    .sda_oe (sda_oe_w)
  );

  int         vectors = 0;
  int         errors  = 0;
  int         viol    = 0;
  logic       prev_oe = 1'b0;
  logic [7:0] mdl  [NREG];
  logic [7:0] wbuf [16];

  // R10 monitor: drive changes seen while the host holds SCL high
  always @(negedge clk) begin
    if (sda_oe_w !== prev_oe && scl_h) viol++;
    prev_oe <= sda_oe_w;
  end

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic b, output logic s);
    tick(Q); sda_h = b;
    tick(Q); scl_h = 1'b1;
    tick(Q); s = sda_line;
    tick(Q); scl_h = 1'b0;
  endtask

  task automatic write_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
    bit_xfer(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(input logic ack_me, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s);
      v[i] = s;
    end
    bit_xfer(~ack_me, s);
  endtask

  task automatic bus_start();
    sda_h = 1'b1; tick(Q);
    scl_h = 1'b1; tick(Q);
    sda_h = 1'b0; tick(Q);
    scl_h = 1'b0;
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; tick(Q);
    scl_h = 1'b1; tick(Q);
    sda_h = 1'b1; tick(Q);
  endtask

  task automatic blk_write(input int n, input int x, input int nsend);
    logic a;
    bus_start();
    write_byte(8'hD2, a); chk("R2 write address ack", a, 1);
    write_byte(8'(n), a); chk("R4 index ack", a, 1);
    write_byte(8'(x), a); chk("R4 count ack", a, 1);
    for (int i = 0; i < nsend; i++) begin
      write_byte(wbuf[i], a);
      if (i < x) begin
        chk("R4 data ack", a, 1);
        mdl[(n + i) % NREG] = wbuf[i];   // R6 wrap in the model
      end else begin
        chk("R5 surplus byte nack", a, 0);
      end
    end
    bus_stop();
  endtask

  task automatic blk_read(input int n, input int nread, input string ctag);
    logic       a;
    logic [7:0] v;
    bus_start();
    write_byte(8'hD2, a); chk("R2 write address ack", a, 1);
    write_byte(8'(n), a); chk("R7 index ack", a, 1);
    bus_start();
    write_byte(8'hD3, a); chk("R2 read address ack", a, 1);
    read_byte(1'b1, v);   chk(ctag, int'(v), int'(mdl[NREG-1]));
    for (int i = 0; i < nread; i++) begin
      read_byte(i != nread - 1, v);
      chk("R7 read data", int'(v), int'(mdl[(n + i) % NREG]));
    end
    bus_stop();
  endtask

  task automatic foreign_addr(input logic [7:0] adr);
    logic a;
    bus_start();
    write_byte(adr, a);   chk("R3 foreign address nack", a, 0);
    write_byte(8'h00, a); chk("R3 ignored index nack", a, 0);
    write_byte(8'h02, a); chk("R3 ignored count nack", a, 0);
    write_byte(8'h5A, a); chk("R3 ignored data nack", a, 0);
    bus_stop();
  endtask

  initial begin
    logic       a;
    logic [7:0] v;
    void'($urandom(32'h1D2C_0DE5));
    for (int i = 0; i < NREG; i++) mdl[i] = (i == NREG - 1) ? 8'(NREG) : 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk("R1 SDA released after reset", int'(sda_oe_w), 0);
    blk_read(0, NREG, "R1 count register reset value");

    // R6 + R8: write 6,7,0 -- count register write coincides with the wrap
    wbuf[0] = 8'h11; wbuf[1] = 8'h05; wbuf[2] = 8'h33;
    blk_write(6, 3, 3);
    blk_read(6, 3, "R8 count byte after write");

    // R6: index byte 13 selects register 5
    wbuf[0] = 8'hA7; wbuf[1] = 8'h5C;
    blk_write(13, 2, 2);
    blk_read(5, 2, "R6 count byte");

    // R5: one counted byte, two surplus
    wbuf[0] = 8'hC3; wbuf[1] = 8'hEE; wbuf[2] = 8'hDD;
    blk_write(2, 1, 3);
    blk_read(2, 2, "R5 count byte");

    // R3: foreign addresses change nothing
    foreign_addr(8'hA4);
    foreign_addr(8'hD0);
    blk_read(0, NREG, "R3 count byte unchanged");

    // R9: host NACKs the count byte, then clocks another byte
    bus_start();
    write_byte(8'hD2, a); chk("R2 write address ack", a, 1);
    write_byte(8'h00, a); chk("R9 index ack", a, 1);
    bus_start();
    write_byte(8'hD3, a); chk("R2 read address ack", a, 1);
    read_byte(1'b0, v);   chk("R9 count byte", int'(v), int'(mdl[NREG-1]));
    read_byte(1'b0, v);   chk("R9 line released after host nack", int'(v), 8'hFF);
    bus_stop();

    // random block writes and reads
    for (int it = 0; it < 12; it++) begin
      int n;
      int x;
      int ns;
      n  = $urandom_range(0, 255);
      x  = $urandom_range(0, 6);
      ns = x + $urandom_range(0, 1);
      for (int k = 0; k < 16; k++) wbuf[k] = 8'($urandom_range(0, 255));
      blk_write(n, x, ns);
      blk_read($urandom_range(0, 255), $urandom_range(1, 8), "R7 count byte");
    end

    chk("R10 drive changes only with SCL low", viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    vectors++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule